// File: doc/BRIEF.md
# Coarse-Grained Hardware Thread Context Switcher

This block picks which of four resident hardware threads feeds instruction fetch in a single-issue core. Each thread owns a program counter and a ready bit, and each has its own register bank, so moving from one thread to another costs no save or restore traffic. The currently active thread keeps running until it issues a memory access that carries an explicit switch request. That thread is then parked with its PC pointing at its next instruction, and a different ready thread takes over on the following cycle.

The successor is found by scanning round-robin, starting at the thread after the one being parked. A parked thread becomes eligible again only when the memory side returns a completion pulse tagged with its thread number. When every thread is parked, the unit stops fetch and raises an idle indication. The first thread whose completion arrives is resumed on the next cycle. The active thread number is also driven out as the upper select bits of the register-bank address.

Top module: `ctx_switcher`

## Requirements
- R1: After reset all four threads are ready (`ready_o` = 4'b1111), thread 0 is active, each thread's PC holds its own entry in `START_PC` (thread k in bits [k*PC_W +: PC_W]), `idle_o` is 0 and `err_o` is 0.
- R2: `fetch_pc_o` is the PC of the thread on `ctx_o`. `ctx_o` is also the register-bank select. When not idle, the thread on `ctx_o` has its ready bit set.
- R3: An instruction issued without a branch advances the active thread's PC by 4 on the next cycle.
- R4: An issued instruction with `br_i` high loads `br_target_i` into the active thread's PC on the next cycle.
- R5: The active thread stays active if the issued instruction has only one of `mem_i` and `swf_i` set, or if no instruction issues.
- R6: An issue with both `mem_i` and `swf_i` high parks the active thread, keeping its updated PC. On the next cycle `ctx_o` shows the first ready thread found scanning upward and wrapping from the parked thread plus one.
- R7: Bit k of `ready_o` is thread k's ready flag. A parked thread's bit stays 0 until `done_i` pulses with `done_ctx_i` = k (a 2-bit thread number). The bit is then 1 on the next cycle.
- R8: When no thread is ready after a switch, `idle_o` goes high and `fetch_vld_o` goes low on the next cycle. While idle, `issue_i` is ignored and no PC changes.
- R9: While idle, a completion for thread k makes thread k active and clears `idle_o` on the next cycle, and fetch resumes at thread k's held PC.
- R10: A completion for a thread whose ready bit is already 1 leaves `ready_o` unchanged and sets `err_o`. `err_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction from the active thread issues this cycle |
| mem_i | input | 1 | The issuing instruction is a memory access |
| swf_i | input | 1 | The issuing instruction requests a thread switch |
| br_i | input | 1 | The issuing instruction redirects its thread's PC |
| br_target_i | input | PC_W | Redirect target |
| done_i | input | 1 | Memory completion pulse |
| done_ctx_i | input | CW | Thread number of the completion |
| fetch_pc_o | output | PC_W | PC of the active thread |
| fetch_vld_o | output | 1 | Fetch enabled (no thread idle condition) |
| ctx_o | output | CW | Active thread, upper register-bank select bits |
| idle_o | output | 1 | No thread is ready |
| ready_o | output | NCTX | Per-thread ready flags |
| err_o | output | 1 | Sticky flag for a completion to a non-parked thread |

## Verification
The hardest state to reach is all four threads parked while their completions are still outstanding, together with a completion that arrives in the same cycle as a switch. The bench reaches the fully parked state on purpose by issuing flagged memory accesses from each thread in turn. It then drives a long pseudo-random run in which completions are much more frequent while idle. Every cycle of that run is compared against an arithmetic model of PCs, ready flags and the round-robin scan.

// File: rtl/ctx_switcher.sv
module ctx_switcher #(
  parameter int NCTX = 4,
  parameter int PC_W = 32,
  parameter int CW   = $clog2(NCTX),
  parameter logic [NCTX*PC_W-1:0] START_PC = {32'h0000_4000, 32'h0000_3000, 32'h0000_2000, 32'h0000_1000}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic            mem_i,
  input  logic            swf_i,
  input  logic            br_i,
  input  logic [PC_W-1:0] br_target_i,
  input  logic            done_i,
  input  logic [CW-1:0]   done_ctx_i,
  output logic [PC_W-1:0] fetch_pc_o,
  output logic            fetch_vld_o,
  output logic [CW-1:0]   ctx_o,
  output logic            idle_o,
  output logic [NCTX-1:0] ready_o,
  output logic            err_o
);
  logic [PC_W-1:0] pc_q [NCTX];
  logic [NCTX-1:0] rdy_q, rdy_d;
  logic [CW-1:0]   cur_q, cur_d, nxt;
  logic            idle_q, idle_d, err_q, err_d, found;

  wire iss = issue_i & ~idle_q;
  wire swt = iss & mem_i & swf_i;

  always_comb begin
    rdy_d = rdy_q;
    err_d = err_q;
    if (done_i) begin
      if (rdy_q[done_ctx_i]) err_d = 1'b1;
      else                   rdy_d[done_ctx_i] = 1'b1;
    end
    if (swt) rdy_d[cur_q] = 1'b0;
    nxt   = cur_q;
    found = 1'b0;
    for (int i = 1; i <= NCTX; i++) begin
      int j;
      j = (int'(cur_q) + i) % NCTX;
      if (!found && rdy_d[j]) begin
        found = 1'b1;
        nxt   = CW'(j);
      end
    end
    cur_d  = cur_q;
    idle_d = idle_q;
    if (swt || idle_q) begin
      cur_d  = nxt;
      idle_d = ~found;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCTX; k++) pc_q[k] <= START_PC[k*PC_W +: PC_W];
      rdy_q  <= '1;
      cur_q  <= '0;
      idle_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (iss) pc_q[cur_q] <= br_i ? br_target_i : pc_q[cur_q] + PC_W'(4);
      rdy_q  <= rdy_d;
      cur_q  <= cur_d;
      idle_q <= idle_d;
      err_q  <= err_d;
    end
  end

  assign fetch_pc_o  = pc_q[cur_q];
  assign fetch_vld_o = ~idle_q;
  assign ctx_o       = cur_q;
  assign idle_o      = idle_q;
  assign ready_o     = rdy_q;
  assign err_o       = err_q;
endmodule

// File: rtl/ctx_switcher_chk.sv
module ctx_switcher_chk #(
  parameter int NCTX = 4,
  parameter int PC_W = 32,
  parameter int CW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic            mem_i,
  input logic            swf_i,
  input logic            br_i,
  input logic [PC_W-1:0] br_target_i,
  input logic            done_i,
  input logic [CW-1:0]   done_ctx_i,
  input logic [PC_W-1:0] fetch_pc_o,
  input logic            fetch_vld_o,
  input logic [CW-1:0]   ctx_o,
  input logic            idle_o,
  input logic [NCTX-1:0] ready_o,
  input logic            err_o
);
  wire live = issue_i & ~idle_o;
  wire flag = mem_i & swf_i;

  assert_active_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_o |-> ready_o[ctx_o]);
  assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (ready_o == '0 && !fetch_vld_o));
  assert_step4_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !br_i && !flag) |=> fetch_pc_o == $past(fetch_pc_o) + PC_W'(4));
  assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && br_i && !flag) |=> fetch_pc_o == $past(br_target_i));
  assert_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !(live && flag)) |=> (ctx_o == $past(ctx_o) && !idle_o));
  assert_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && flag) |=> (idle_o || ctx_o != $past(ctx_o)));
  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && done_i) |=> (!idle_o && ctx_o == $past(done_ctx_i)));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind ctx_switcher ctx_switcher_chk #(.NCTX(NCTX), .PC_W(PC_W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .mem_i(mem_i), .swf_i(swf_i),
  .br_i(br_i), .br_target_i(br_target_i), .done_i(done_i), .done_ctx_i(done_ctx_i),
  .fetch_pc_o(fetch_pc_o), .fetch_vld_o(fetch_vld_o), .ctx_o(ctx_o), .idle_o(idle_o),
  .ready_o(ready_o), .err_o(err_o));

// File: tb/ctx_switcher_tb_top.sv
`timescale 1ns/1ps
module ctx_switcher_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_i = 0, mem_i = 0, swf_i = 0, br_i = 0, done_i = 0;
  logic [31:0] br_target_i = '0;
  logic [1:0]  done_ctx_i = '0;
  logic [31:0] fetch_pc_o;
  logic        fetch_vld_o, idle_o, err_o;
  logic [1:0]  ctx_o;
  logic [3:0]  ready_o;

  always #2.5 clk = ~clk;

  ctx_switcher dut_i (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] m_pc [4];
  logic [3:0]  m_rdy;
  int          m_cur;
  bit          m_idle, m_err;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    check(fetch_vld_o == !m_idle, "R8 fetch_vld", 32'(fetch_vld_o), 32'(!m_idle));
    check(idle_o == m_idle, "R8 idle", 32'(idle_o), 32'(m_idle));
    check(int'(ctx_o) == m_cur, "R6 ctx", 32'(ctx_o), 32'(m_cur));
    check(fetch_pc_o == m_pc[m_cur], "R3 fetch_pc", fetch_pc_o, m_pc[m_cur]);
    check(ready_o == m_rdy, "R7 ready", 32'(ready_o), 32'(m_rdy));
    check(err_o == m_err, "R10 err", 32'(err_o), 32'(m_err));
  endtask

  task automatic step(input bit is, input bit mm, input bit sf, input bit br,
                      input logic [31:0] tg, input bit dn, input logic [1:0] dc);
    bit iss, swt, found;
    logic [3:0] r;
    int nc;
    @(negedge clk);
    cmp_model();
    issue_i = is; mem_i = mm; swf_i = sf; br_i = br; br_target_i = tg;
    done_i = dn; done_ctx_i = dc;
    iss = is && !m_idle;
    swt = iss && mm && sf;
    r = m_rdy;
    if (dn) begin
      if (r[dc]) m_err = 1; else r[dc] = 1'b1;
    end
    if (swt) r[m_cur] = 1'b0;
    @(posedge clk);
    #1;
    if (iss) m_pc[m_cur] = br ? tg : m_pc[m_cur] + 32'd4;
    if (swt || m_idle) begin
      found = 0; nc = m_cur;
      for (int i = 1; i <= 4; i++)
        if (!found && r[(m_cur + i) % 4]) begin found = 1; nc = (m_cur + i) % 4; end
      m_cur = nc; m_idle = !found;
    end
    m_rdy = r;
    issue_i = 0; mem_i = 0; swf_i = 0; br_i = 0; done_i = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    nerr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_pc[k] = 32'h1000 * (k + 1);
    m_rdy = 4'hF; m_cur = 0; m_idle = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    check(fetch_pc_o == 32'h1000 && ctx_o == 0, "R1 pc/ctx", fetch_pc_o, 32'h1000);
    check(ready_o == 4'hF && !idle_o && !err_o && fetch_vld_o, "R1 flags",
          {26'd0, ready_o, idle_o, err_o}, {26'd0, 4'hF, 2'b00});
    step(1, 0, 0, 0, 0, 0, 0);
    check(fetch_pc_o == 32'h1004, "R3 plain issue", fetch_pc_o, 32'h1004);
    step(1, 0, 0, 1, 32'h1800, 0, 0);
    check(fetch_pc_o == 32'h1800, "R4 redirect", fetch_pc_o, 32'h1800);
    step(1, 1, 0, 0, 0, 0, 0);
    check(ctx_o == 0 && fetch_pc_o == 32'h1804, "R5 mem no flag", fetch_pc_o, 32'h1804);
    step(1, 0, 1, 0, 0, 0, 0);
    check(ctx_o == 0 && fetch_pc_o == 32'h1808, "R5 flag no mem", fetch_pc_o, 32'h1808);
    step(0, 1, 1, 0, 0, 0, 0);
    check(ctx_o == 0, "R5 no issue", 32'(ctx_o), 0);
    step(1, 1, 1, 0, 0, 0, 0);
    check(ctx_o == 1 && fetch_pc_o == 32'h2000, "R6 switch to 1", fetch_pc_o, 32'h2000);
    check(ready_o == 4'b1110, "R7 parked", 32'(ready_o), 32'hE);
    check(ctx_o == 2'd1, "R2 bank select", 32'(ctx_o), 1);
    step(1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0);
    check(ctx_o == 3 && fetch_pc_o == 32'h4000, "R6 switch to 3", fetch_pc_o, 32'h4000);
    step(1, 1, 1, 0, 0, 0, 0);
    check(idle_o && !fetch_vld_o && ready_o == 0, "R8 all parked", 32'(idle_o), 1);
    step(1, 0, 0, 0, 0, 0, 0);
    check(idle_o && ctx_o == 3, "R8 issue ignored", 32'(ctx_o), 3);
    step(0, 0, 0, 0, 0, 1, 2'd0);
    check(!idle_o && ctx_o == 0 && fetch_pc_o == 32'h180C, "R9 wake ctx0", fetch_pc_o, 32'h180C);
    step(0, 0, 0, 0, 0, 1, 2'd0);
    check(err_o && ready_o == 4'b0001, "R10 stray done", {28'd0, ready_o}, 32'h1);
    step(0, 0, 0, 0, 0, 1, 2'd2);
    check(ready_o == 4'b0101 && err_o, "R7 done ctx2 / R10 sticky", 32'(ready_o), 32'h5);
    for (int n = 0; n < 4000; n++) begin
      bit dn;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dn = m_idle ? lfsr[6] : (lfsr[6] & lfsr[7] & lfsr[8]);
      step(lfsr[0] | lfsr[1], lfsr[2], lfsr[3], lfsr[4] & lfsr[5],
           {14'd0, lfsr, 2'b00}, dn, lfsr[10:9]);
    end
    @(negedge clk);
    cmp_model();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule